// File: doc/BRIEF.md
# SPI Link Byte-Stuffing Codec

This block sits between a host-side byte interface and an SPI shift engine. A small set of byte values is reserved on the link as control characters, which signal link state and flow control. Because payload bytes may take any value, the block's transmit half rewrites every payload byte that collides with a reserved value. Its receive half undoes that rewriting and separates control events from payload.

The encoder accepts payload bytes and control requests on two valid/ready inputs. It drives a single output byte stream that the downstream shifter paces with a ready signal. A colliding payload byte goes out as the escape byte 0xFB followed by the original byte XOR 0x20. A control request goes out as its raw byte.

The decoder takes the received byte stream with a per-byte valid strobe. It produces a registered payload strobe, a control-event strobe carrying the raw code, and a protocol-error pulse. Unescaped idle fill bytes are dropped silently.

Top module: `spi_stuff_codec`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `rx_data_valid`, `rx_ctrl_valid` and `rx_err` are 0, and `tx_data_ready` is 1 when no control request is pending.
- R2: A payload byte outside the reserved set {0x00, 0xF3, 0xF5, 0xFA, 0xFB, 0xFD, 0xFF} leaves the encoder unchanged as a single output byte, in order of acceptance.
- R3: A payload byte inside the reserved set leaves as two bytes, 0xFB and then the byte XOR 0x20. `tx_data_ready` is 0 in the cycle after it is accepted, so no new payload is taken until the second byte has moved out.
- R4: A control request leaves as its raw byte without escaping. When a control request and a payload byte are valid together, the control request is taken first and `tx_data_ready` is 0.
- R5: While `out_valid` is 1 and `out_ready` is 0, the output byte and its valid hold steady into the next cycle.
- R6: A received byte outside the reserved set, not preceded by an unconsumed 0xFB, gives `rx_data_valid` with that byte one cycle after it is presented.
- R7: A received 0xFB followed by a byte X, where X XOR 0x20 is reserved, gives `rx_data_valid` with X XOR 0x20 one cycle after X. The 0xFB itself gives no output.
- R8: A received unescaped reserved byte other than 0xFB and 0xF5 gives `rx_ctrl_valid` with the byte in `rx_ctrl`, and gives no payload strobe.
- R9: A received unescaped 0xF5 gives no payload, control or error output.
- R10: A received 0xFB followed by a byte whose XOR with 0x20 is not reserved gives a one-cycle `rx_err` and no payload. The next byte is decoded as unescaped.
- R11: Cycles without `rx_valid` produce no decoder output and do not clear a pending escape.
- R12: Reset clears a pending escape, so a byte received after reset is decoded as unescaped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data_valid | input | 1 | Payload byte offered |
| tx_data_ready | output | 1 | Payload byte taken this cycle when valid |
| tx_data | input | 8 | Payload byte |
| tx_ctrl_valid | input | 1 | Control request offered |
| tx_ctrl_ready | output | 1 | Control request taken this cycle when valid |
| tx_ctrl | input | 8 | Raw control byte to send |
| out_valid | output | 1 | Encoded byte present |
| out_ready | input | 1 | Downstream takes the encoded byte |
| out_byte | output | 8 | Encoded link byte |
| rx_valid | input | 1 | Received link byte present |
| rx_byte | input | 8 | Received link byte |
| rx_data_valid | output | 1 | Recovered payload strobe |
| rx_data | output | 8 | Recovered payload byte |
| rx_ctrl_valid | output | 1 | Control event strobe |
| rx_ctrl | output | 8 | Control event code |
| rx_err | output | 1 | Malformed escape pair pulse |

## Verification
Two encoder conditions are hard to reach together: an escape pair still in flight while the downstream stalls, and a control request competing with payload. The stimulus reaches both by throttling `out_ready` on a repeating pattern while it offers reserved payload and simultaneous control requests.

A second hard case is an escape left pending across idle cycles or across a reset. Directed receive sequences cover it by presenting 0xFB, then gaps or a reset, and then the follow-up byte.

A loopback phase feeds every one of the 256 byte values through the encoder into the decoder under stalls, so the two halves are checked as exact inverses.

// File: rtl/spi_stuff_codec.sv
module spi_stuff_codec #(
  parameter int W = 8,
  parameter logic [W-1:0] ESC = 8'hFB,
  parameter logic [W-1:0] IDLE = 8'hF5,
  parameter logic [W-1:0] FLIP = 8'h20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_data_valid,
  output logic         tx_data_ready,
  input  logic [W-1:0] tx_data,
  input  logic         tx_ctrl_valid,
  output logic         tx_ctrl_ready,
  input  logic [W-1:0] tx_ctrl,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_byte,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  output logic         rx_data_valid,
  output logic [W-1:0] rx_data,
  output logic         rx_ctrl_valid,
  output logic [W-1:0] rx_ctrl,
  output logic         rx_err
);

  function automatic logic reserved(input logic [W-1:0] b);
    return b == 8'hFD || b == 8'hFA || b == ESC || b == IDLE ||
           b == 8'hF3 || b == 8'h00 || b == 8'hFF;
  endfunction

  // transmit side
  logic         pend;
  logic [W-1:0] pend_byte;
  logic         slot_free;

  assign slot_free     = !out_valid || out_ready;
  assign tx_ctrl_ready = slot_free && !pend;
  assign tx_data_ready = slot_free && !pend && !tx_ctrl_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      pend      <= 1'b0;
      pend_byte <= '0;
    end else if (slot_free) begin
      if (pend) begin
        out_valid <= 1'b1;
        out_byte  <= pend_byte;
        pend      <= 1'b0;
      end else if (tx_ctrl_valid) begin
        out_valid <= 1'b1;
        out_byte  <= tx_ctrl;
      end else if (tx_data_valid) begin
        out_valid <= 1'b1;
        if (reserved(tx_data)) begin
          out_byte  <= ESC;
          pend      <= 1'b1;
          pend_byte <= tx_data ^ FLIP;
        end else begin
          out_byte <= tx_data;
        end
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_PEND_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !tx_data_ready && !tx_ctrl_ready);  // R3
  AST_SECOND_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && pend) |=> (out_valid && !reserved(out_byte)));  // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));  // R5
  AST_CTRL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ctrl_valid |-> !tx_data_ready);  // R4

  // receive side
  logic         esc_seen;
  logic [W-1:0] unflip;
  assign unflip = rx_byte ^ FLIP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esc_seen      <= 1'b0;
      rx_data_valid <= 1'b0;
      rx_data       <= '0;
      rx_ctrl_valid <= 1'b0;
      rx_ctrl       <= '0;
      rx_err        <= 1'b0;
    end else begin
      rx_data_valid <= 1'b0;
      rx_ctrl_valid <= 1'b0;
      rx_err        <= 1'b0;
      if (rx_valid) begin
        if (esc_seen) begin
          esc_seen <= 1'b0;
          if (reserved(unflip)) begin
            rx_data_valid <= 1'b1;
            rx_data       <= unflip;
          end else begin
            rx_err <= 1'b1;
          end
        end else if (rx_byte == ESC) begin
          esc_seen <= 1'b1;
        end else if (rx_byte == IDLE) begin
          esc_seen <= 1'b0;
        end else if (reserved(rx_byte)) begin
          rx_ctrl_valid <= 1'b1;
          rx_ctrl       <= rx_byte;
        end else begin
          rx_data_valid <= 1'b1;
          rx_data       <= rx_byte;
        end
      end
    end
  end

  AST_RX_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rx_data_valid, rx_ctrl_valid, rx_err}) <= 1);  // R8
  AST_CTRL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ctrl_valid |-> (reserved(rx_ctrl) && rx_ctrl != ESC && rx_ctrl != IDLE));  // R8
  AST_QUIET_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !(rx_data_valid || rx_ctrl_valid || rx_err));  // R11
  AST_ESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_seen && !rx_valid) |=> esc_seen);  // R11

endmodule

// File: tb/spi_stuff_codec_test.sv
module spi_stuff_codec_test;
  logic clk = 0, rst_n = 0;
  logic tx_data_valid = 0, tx_ctrl_valid = 0, out_ready = 1;
  logic [7:0] tx_data = 0, tx_ctrl = 0;
  logic b_rx_valid = 0; logic [7:0] b_rx_byte = 0;
  logic loop = 0;
  logic tx_data_ready, tx_ctrl_ready, out_valid;
  logic [7:0] out_byte, rx_data, rx_ctrl;
  logic rx_valid, rx_data_valid, rx_ctrl_valid, rx_err;
  logic [7:0] rx_byte;

  assign rx_valid = loop ? (out_valid && out_ready) : b_rx_valid;
  assign rx_byte  = loop ? out_byte : b_rx_byte;

  spi_stuff_codec uut (
    .clk(clk), .rst_n(rst_n),
    .tx_data_valid(tx_data_valid), .tx_data_ready(tx_data_ready), .tx_data(tx_data),
    .tx_ctrl_valid(tx_ctrl_valid), .tx_ctrl_ready(tx_ctrl_ready), .tx_ctrl(tx_ctrl),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_data_valid(rx_data_valid), .rx_data(rx_data),
    .rx_ctrl_valid(rx_ctrl_valid), .rx_ctrl(rx_ctrl), .rx_err(rx_err));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int stall_mode = 0;
  bit m_esc = 0, e_dv = 0, e_cv = 0, e_err = 0;
  logic [7:0] e_d = 0, e_c = 0;
  logic [7:0] q[$];
  bit esc_acc = 0, stall_prev = 0;
  logic [7:0] stall_byte = 0;

  function automatic bit rsv(input logic [7:0] b);
    return b == 8'hFD || b == 8'hFA || b == 8'hFB || b == 8'hF5 ||
           b == 8'hF3 || b == 8'h00 || b == 8'hFF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!out_valid, "R1 out_valid", {7'd0, out_valid}, 0);
      chk(!rx_data_valid && !rx_ctrl_valid && !rx_err, "R1 rx strobes",
          {5'd0, rx_data_valid, rx_ctrl_valid, rx_err}, 0);
      chk(tx_ctrl_valid || tx_data_ready, "R1 tx_data_ready", {7'd0, tx_data_ready}, 1);
      m_esc = 0; e_dv = 0; e_cv = 0; e_err = 0;
      q.delete(); esc_acc = 0; stall_prev = 0;
    end else begin
      chk(rx_data_valid == e_dv && (!e_dv || rx_data == e_d), "R6 R7 R9 R12 rx_data",
          rx_data_valid ? rx_data : 8'hxx, e_dv ? e_d : 8'hxx);
      chk(rx_ctrl_valid == e_cv && (!e_cv || rx_ctrl == e_c), "R8 R9 rx_ctrl",
          rx_ctrl_valid ? rx_ctrl : 8'hxx, e_cv ? e_c : 8'hxx);
      chk(rx_err == e_err, "R10 R11 rx_err", {7'd0, rx_err}, {7'd0, e_err});
      e_dv = 0; e_cv = 0; e_err = 0;
      if (rx_valid) begin
        if (m_esc) begin
          m_esc = 0;
          if (rsv(rx_byte ^ 8'h20)) begin e_dv = 1; e_d = rx_byte ^ 8'h20; end
          else e_err = 1;
        end else if (rx_byte == 8'hFB) m_esc = 1;
        else if (rx_byte == 8'hF5) ;
        else if (rsv(rx_byte)) begin e_cv = 1; e_c = rx_byte; end
        else begin e_dv = 1; e_d = rx_byte; end
      end

      if (esc_acc) chk(!tx_data_ready, "R3 ready low during escape", {7'd0, tx_data_ready}, 0);
      if (stall_prev) chk(out_valid && out_byte == stall_byte, "R5 hold under stall", out_byte, stall_byte);
      stall_prev = out_valid && !out_ready;
      stall_byte = out_byte;
      if (tx_ctrl_valid && tx_data_valid)
        chk(!tx_data_ready, "R4 ctrl priority", {7'd0, tx_data_ready}, 0);
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(0, "R2 R3 R4 unexpected byte", out_byte, 8'hxx);
        else begin
          chk(out_byte == q[0], "R2 R3 R4 out_byte", out_byte, q[0]);
          void'(q.pop_front());
        end
      end
      esc_acc = 0;
      if (tx_ctrl_valid && tx_ctrl_ready) q.push_back(tx_ctrl);
      else if (tx_data_valid && tx_data_ready) begin
        if (rsv(tx_data)) begin
          q.push_back(8'hFB); q.push_back(tx_data ^ 8'h20); esc_acc = 1;
        end else q.push_back(tx_data);
      end
    end
  end

  initial begin
    int n = 0;
    forever begin
      @(posedge clk); #2;
      n++;
      out_ready = (stall_mode == 0) ? 1'b1 : ((n % 3) != 0);
    end
  end

  task automatic do_reset();
    @(posedge clk); #2; rst_n = 0;
    repeat (2) @(posedge clk); #2; rst_n = 1;
  endtask

  task automatic put_data(input logic [7:0] b);
    tx_data_valid = 1; tx_data = b;
    do @(negedge clk); while (!tx_data_ready);
    @(posedge clk); #2; tx_data_valid = 0;
  endtask

  task automatic put_ctrl(input logic [7:0] b);
    tx_ctrl_valid = 1; tx_ctrl = b;
    do @(negedge clk); while (!tx_ctrl_ready);
    @(posedge clk); #2; tx_ctrl_valid = 0;
  endtask

  task automatic put_both(input logic [7:0] c, input logic [7:0] d);
    tx_ctrl_valid = 1; tx_ctrl = c; tx_data_valid = 1; tx_data = d;
    do @(negedge clk); while (!tx_ctrl_ready);
    @(posedge clk); #2; tx_ctrl_valid = 0;
    do @(negedge clk); while (!tx_data_ready);
    @(posedge clk); #2; tx_data_valid = 0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    b_rx_valid = 1; b_rx_byte = b;
    @(posedge clk); #2; b_rx_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk); #2; rst_n = 1;
    repeat (2) @(posedge clk); #2;
    // encoder, free-running downstream: R2 R3 R4
    put_data(8'h41); put_data(8'hFD); put_data(8'h00); put_data(8'hFF);
    put_data(8'h7E); put_data(8'hFB);
    put_ctrl(8'hFA);
    put_both(8'hF3, 8'h55);
    // encoder under stalls: R5
    stall_mode = 1;
    put_data(8'hF5); put_data(8'hDD); put_data(8'h20); put_ctrl(8'h00);
    put_both(8'hFD, 8'hFA);
    repeat (12) @(posedge clk); #2;
    stall_mode = 0;
    // decoder direct: R6..R11
    rx_send(8'h41); rx_send(8'hFD); rx_send(8'hF5);
    rx_send(8'hFB); rx_send(8'hDD);
    rx_send(8'hFB); rx_send(8'h41);
    rx_send(8'h42);
    rx_send(8'h00); rx_send(8'hFF);
    rx_send(8'hFB); repeat (3) @(posedge clk); #2; rx_send(8'hD5);
    // R12 escape cleared by reset
    rx_send(8'hFB); do_reset(); rx_send(8'h20); rx_send(8'hDB);
    repeat (3) @(posedge clk); #2;
    // loopback inverse under stalls
    loop = 1; stall_mode = 1;
    for (int v = 0; v < 256; v++) put_data(v[7:0]);
    put_ctrl(8'hF3); put_ctrl(8'hF5); put_data(8'hFB);
    repeat (20) @(posedge clk); #2;
    @(negedge clk);
    chk(q.size() == 0, "R2 R3 drained", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule